// File: doc/BRIEF.md
# Frequency acquisition and lock sequencer

This block steers a numerically controlled oscillator onto the rate of an incoming data stream. Once per measurement window it receives two counts taken over the same fixed interval. One count is of oscillator edges. The other is of edges derived from data transitions. It compares the two counts in parts per million using integer multiplies, and moves a tuning word until the oscillator count agrees with the data count.

Every acquisition starts with the tuning word at zero and climbs in large steps. The step is halved whenever the oscillator overshoots the data rate and whenever the error falls below a programmable coarse threshold. It never goes below one LSB. An overshoot takes back the last step. When the error is within 250 ppm, the sequencer drops its loss-of-lock flag, freezes the tuning word and enables the downstream phase loop. While locked it tolerates errors up to 1000 ppm. A larger error raises loss-of-lock again and restarts the sweep from zero.

Top module: `freq_acq_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters acquisition. After that edge `lol` is 1, `phase_en` is 0, `tune_word` is 0 and the step size is INIT_STEP (default 256).
- R2: The error e is the absolute difference of `osc_cnt` and `ref_cnt`. The lock band is e*1e6 <= 250*ref_cnt. The unlock condition is e*1e6 > 1000*ref_cnt. Both boundary values themselves count as inside.
- R3: In acquisition, a window whose error is inside the lock band clears `lol`, sets `phase_en` and leaves `tune_word` unchanged, all one cycle after `win_valid`.
- R4: While locked, a window past the unlock condition sets `lol`, clears `phase_en`, forces `tune_word` to 0 and restores the step to INIT_STEP.
- R5: While locked, a window with error at or below 1000 ppm keeps the lock and leaves `tune_word` unchanged.
- R6: In acquisition, a window outside the band with `osc_cnt` < `ref_cnt` adds the current step to `tune_word`.
- R7: In acquisition, a window outside the band with `osc_cnt` > `ref_cnt` subtracts the last added step and halves the step. A second such window in a row moves nothing back.
- R8: A rising window halves the step when e*1e6 <= `coarse_ppm`*ref_cnt. The step never falls below 1.
- R9: If adding the step would pass the largest tuning word, `tune_word` goes to 0 and the step returns to INIT_STEP, and acquisition continues.
- R10: `tune_word`, `lol` and `phase_en` change only in the cycle after a `win_valid` window or a reset.
- R11: With an oscillator count linear in the tuning word (10 counts per LSB), lock is reached within 64 windows of an acquisition start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_valid | input | 1 | One-cycle strobe: a measurement window's counts are valid |
| osc_cnt | input | CNT_W | Oscillator edges counted over the window |
| ref_cnt | input | CNT_W | Data-derived edges counted over the same window |
| coarse_ppm | input | CPPM_W | Error in ppm below which a rising step also halves the step |
| tune_word | output | TUNE_W | Oscillator tuning word |
| lol | output | 1 | Loss-of-lock flag, high during acquisition |
| phase_en | output | 1 | Hands control to the phase loop once frequency is locked |

## Verification
The hardest condition to reach is the wrap of the tuning word. It needs a data rate the oscillator can never reach, held long enough for the coarse steps to walk off the top of the range. The bench drives a reference count above the oscillator's maximum count for enough windows, then checks that the word returns to zero. The one-LSB floor on the step cannot be seen from the ports. The bench reaches it with a run of overshooting windows at tuning word zero, then shows it through the size of the next rising step. The ppm boundaries are hit exactly by driving hand-picked count pairs instead of the linear oscillator model.

// File: rtl/fas_pkg.sv
package fas_pkg;
  typedef enum logic {ST_ACQ = 1'b0, ST_LOCK = 1'b1} fas_state_e;

  localparam int unsigned LOCK_PPM   = 250;
  localparam int unsigned UNLOCK_PPM = 1000;

  // true when gap exceeds ppm parts per million of base
  function automatic logic ppm_above(input logic [31:0] gap,
                                     input logic [31:0] base,
                                     input logic [31:0] ppm);
    return (64'(gap) * 64'd1000000) > (64'(base) * 64'(ppm));
  endfunction
endpackage

// File: rtl/fas_err_cmp.sv
module fas_err_cmp import fas_pkg::*; #(
  parameter int CNT_W  = 16,
  parameter int CPPM_W = 20
) (
  input  logic [CNT_W-1:0]  osc_cnt,
  input  logic [CNT_W-1:0]  ref_cnt,
  input  logic [CPPM_W-1:0] coarse_ppm,
  output logic              osc_slow,
  output logic              in_band,
  output logic              past_unlock,
  output logic              below_coarse
);
  logic [CNT_W-1:0] gap;

  always_comb begin
    gap          = (osc_cnt >= ref_cnt) ? osc_cnt - ref_cnt : ref_cnt - osc_cnt;
    osc_slow     = osc_cnt < ref_cnt;
    in_band      = !ppm_above(32'(gap), 32'(ref_cnt), LOCK_PPM);
    past_unlock  = ppm_above(32'(gap), 32'(ref_cnt), UNLOCK_PPM);
    below_coarse = !ppm_above(32'(gap), 32'(ref_cnt), 32'(coarse_ppm));
  end
endmodule

// File: rtl/fas_step_sched.sv
module fas_step_sched #(
  parameter int TUNE_W    = 12,
  parameter int INIT_STEP = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              shrink,
  output logic [TUNE_W-1:0] step_q
);
  localparam logic [TUNE_W-1:0] STEP_RST = TUNE_W'(INIT_STEP);

  always_ff @(posedge clk) begin
    if (rst || restart)
      step_q <= STEP_RST;
    else if (shrink && step_q > TUNE_W'(1))
      step_q <= step_q >> 1;
  end
endmodule

// File: rtl/freq_acq_seq.sv
module freq_acq_seq #(
  parameter int CNT_W     = 16,
  parameter int TUNE_W    = 12,
  parameter int INIT_STEP = 256,
  parameter int CPPM_W    = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              win_valid,
  input  logic [CNT_W-1:0]  osc_cnt,
  input  logic [CNT_W-1:0]  ref_cnt,
  input  logic [CPPM_W-1:0] coarse_ppm,
  output logic [TUNE_W-1:0] tune_word,
  output logic              lol,
  output logic              phase_en
);
  import fas_pkg::*;

  fas_state_e        state_q;
  logic [TUNE_W-1:0] last_step;
  logic [TUNE_W-1:0] step_q;
  logic [TUNE_W:0]   sum_w;
  logic osc_slow, in_band, past_unlock, below_coarse;
  logic ev_lock, ev_unlock, ev_rise, ev_back, ev_wrap, ev_restart, ev_shrink;

  fas_err_cmp #(.CNT_W(CNT_W), .CPPM_W(CPPM_W)) u_cmp (
    .osc_cnt(osc_cnt), .ref_cnt(ref_cnt), .coarse_ppm(coarse_ppm),
    .osc_slow(osc_slow), .in_band(in_band), .past_unlock(past_unlock),
    .below_coarse(below_coarse)
  );

  fas_step_sched #(.TUNE_W(TUNE_W), .INIT_STEP(INIT_STEP)) u_step (
    .clk(clk), .rst(rst), .restart(ev_restart), .shrink(ev_shrink), .step_q(step_q)
  );

  // named window events
  always_comb begin
    sum_w      = {1'b0, tune_word} + {1'b0, step_q};
    ev_lock    = win_valid && state_q == ST_ACQ && in_band;
    ev_unlock  = win_valid && state_q == ST_LOCK && past_unlock;
    ev_wrap    = win_valid && state_q == ST_ACQ && !in_band && osc_slow && sum_w[TUNE_W];
    ev_rise    = win_valid && state_q == ST_ACQ && !in_band && osc_slow && !sum_w[TUNE_W];
    ev_back    = win_valid && state_q == ST_ACQ && !in_band && !osc_slow;
    ev_restart = ev_unlock || ev_wrap;
    ev_shrink  = (ev_rise && below_coarse) || ev_back;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_ACQ;
      phase_en  <= 1'b0;
      tune_word <= '0;
      last_step <= '0;
    end else begin
      if (ev_lock) begin
        state_q  <= ST_LOCK;
        phase_en <= 1'b1;
      end
      if (ev_unlock) begin
        state_q  <= ST_ACQ;
        phase_en <= 1'b0;
      end
      if (ev_restart) begin
        tune_word <= '0;
        last_step <= '0;
      end else if (ev_rise) begin
        tune_word <= sum_w[TUNE_W-1:0];
        last_step <= step_q;
      end else if (ev_back) begin
        tune_word <= (tune_word >= last_step) ? tune_word - last_step : '0;
        last_step <= '0;
      end
    end
  end

  assign lol = (state_q == ST_ACQ);
endmodule

// File: rtl/fas_chk.sv
module fas_chk #(
  parameter int TUNE_W    = 12,
  parameter int INIT_STEP = 256
) (
  input logic              clk,
  input logic              rst,
  input logic              win_valid,
  input logic [TUNE_W-1:0] tune_word,
  input logic              lol,
  input logic              phase_en,
  input logic [TUNE_W-1:0] step_q,
  input logic              past_unlock,
  input logic              ev_lock,
  input logic              ev_unlock,
  input logic              ev_rise
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (lol && !phase_en && tune_word == '0 && step_q == TUNE_W'(INIT_STEP)));

  // R3
  lock_grant_chk: assert property (@(posedge clk) disable iff (rst)
    ev_lock |=> (!lol && phase_en));

  // R3
  handoff_excl_chk: assert property (@(posedge clk) disable iff (rst)
    phase_en != lol);

  // R4
  unlock_restart_chk: assert property (@(posedge clk) disable iff (rst)
    ev_unlock |=> (lol && !phase_en && tune_word == '0 && step_q == TUNE_W'(INIT_STEP)));

  // R5
  hold_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (!lol && win_valid && !past_unlock) |=> (!lol && $stable(tune_word)));

  // R6
  rise_up_chk: assert property (@(posedge clk) disable iff (rst)
    ev_rise |=> (tune_word > $past(tune_word)));

  // R8
  step_floor_chk: assert property (@(posedge clk) disable iff (rst)
    step_q != '0);

  // R10
  quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !win_valid |=> ($stable(tune_word) && $stable(lol) && $stable(phase_en)));
endmodule

bind freq_acq_seq fas_chk #(.TUNE_W(TUNE_W), .INIT_STEP(INIT_STEP)) u_chk (
  .clk(clk), .rst(rst), .win_valid(win_valid), .tune_word(tune_word),
  .lol(lol), .phase_en(phase_en), .step_q(step_q), .past_unlock(past_unlock),
  .ev_lock(ev_lock), .ev_unlock(ev_unlock), .ev_rise(ev_rise)
);

// File: tb/sim_freq_acq_seq.sv
module sim_freq_acq_seq;
  localparam int CNT_W = 16, TUNE_W = 12, INIT_STEP = 256, CPPM_W = 20;
  localparam int TMAX = (1 << TUNE_W) - 1;
  localparam int OSC0 = 2000, GAIN = 10, COARSE = 20000;

  logic clk = 1'b0, rst = 1'b1, win_valid = 1'b0;
  logic [CNT_W-1:0] osc_cnt = '0, ref_cnt = '0;
  logic [CPPM_W-1:0] coarse_ppm = CPPM_W'(COARSE);
  logic [TUNE_W-1:0] tune_word;
  logic lol, phase_en;

  freq_acq_seq #(.CNT_W(CNT_W), .TUNE_W(TUNE_W), .INIT_STEP(INIT_STEP), .CPPM_W(CPPM_W)) u0 (
    .clk(clk), .rst(rst), .win_valid(win_valid), .osc_cnt(osc_cnt), .ref_cnt(ref_cnt),
    .coarse_ppm(coarse_ppm), .tune_word(tune_word), .lol(lol), .phase_en(phase_en));

  always #4 clk = ~clk;

  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  // behavioural reference model
  int m_tune, m_step, m_last, n_back = 0, n_wrap = 0;
  bit m_lock;
  string m_tag = "R1";
  longint md, mr;

  always @(posedge clk) begin
    if (rst) begin
      m_tune = 0; m_step = INIT_STEP; m_last = 0; m_lock = 1'b0; m_tag = "R1";
    end else if (win_valid) begin
      mr = longint'(ref_cnt);
      md = (osc_cnt > ref_cnt) ? longint'(osc_cnt) - mr : mr - longint'(osc_cnt);
      if (!m_lock) begin
        if (md * 1000000 <= mr * 250) begin
          m_lock = 1'b1; m_tag = "R3";
        end else if (osc_cnt < ref_cnt) begin
          if (m_tune + m_step > TMAX) begin
            m_tune = 0; m_step = INIT_STEP; m_last = 0; m_tag = "R9"; n_wrap++;
          end else begin
            m_tune += m_step; m_last = m_step; m_tag = "R6";
            if (md * 1000000 <= mr * COARSE && m_step > 1) begin
              m_step /= 2; m_tag = "R8";
            end
          end
        end else begin
          m_tune -= m_last; m_last = 0; m_tag = "R7"; n_back++;
          if (m_step > 1) m_step /= 2;
        end
      end else if (md * 1000000 > mr * 1000) begin
        m_lock = 1'b0; m_tune = 0; m_step = INIT_STEP; m_last = 0; m_tag = "R4";
      end else m_tag = "R5";
    end else m_tag = "R10";
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      compared++;
      if (int'(tune_word) != m_tune || lol != !m_lock || phase_en != m_lock) begin
        mismatched++;
        $display("FAIL %s: tune/lol/en = %0d/%0b/%0b expected %0d/%0b/%0b",
                 m_tag, tune_word, lol, phase_en, m_tune, !m_lock, m_lock);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic win(input int osc, input int rf);
    osc_cnt = CNT_W'(osc); ref_cnt = CNT_W'(rf); win_valid = 1'b1;
    @(negedge clk); win_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic win_lin(input int rf);
    win(OSC0 + m_tune * GAIN, rf);
  endtask

  task automatic acquire(input int rf, output int n);
    n = 0;
    while (lol && n < 64) begin win_lin(rf); n++; end
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected finish");
    finish_run();
  end

  initial begin
    int n, t_lock, w0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(lol && !phase_en && tune_word == 0, "R1", int'(tune_word), 0);
    // R6 first rising step equals INIT_STEP
    win_lin(38003);
    chk(tune_word == INIT_STEP, "R6", int'(tune_word), INIT_STEP);
    // R11 / R3 lock within bound
    acquire(38003, n);
    chk(!lol, "R11", n, 64);
    chk(phase_en, "R3", int'(phase_en), 1);
    chk(n_back > 0, "R7", n_back, 1);
    t_lock = int'(tune_word);
    // R2 / R5 exactly 1000 ppm keeps lock
    win(40040, 40000);
    chk(!lol && int'(tune_word) == t_lock, "R5", int'(tune_word), t_lock);
    // R10 counts ignored without strobe
    osc_cnt = 1; ref_cnt = 60000;
    repeat (20) @(negedge clk);
    chk(!lol && int'(tune_word) == t_lock, "R10", int'(tune_word), t_lock);
    // R4 / R2 one count past 1000 ppm unlocks
    win(40041, 40000);
    chk(lol && !phase_en && tune_word == 0, "R4", int'(tune_word), 0);
    // R2 exactly 250 ppm locks
    win(40010, 40000);
    chk(!lol && phase_en, "R2", int'(lol), 0);
    win(40041, 40000);
    // R11 reacquire a new rate
    acquire(20007, n);
    chk(!lol, "R11", n, 64);
    // R9 unreachable rate wraps the word
    win_lin(60000);
    chk(lol && tune_word == 0, "R4", int'(tune_word), 0);
    w0 = n_wrap;
    for (int i = 0; i < 40 && n_wrap == w0; i++) win_lin(60000);
    chk(n_wrap > w0 && tune_word == 0 && lol, "R9", int'(tune_word), 0);
    // R7 overshoot at zero moves nothing back
    win_lin(1000);
    win_lin(1000);
    chk(tune_word == 0, "R7", int'(tune_word), 0);
    // R8 step floor of one LSB
    for (int i = 0; i < 10; i++) win_lin(1000);
    win_lin(38003);
    chk(tune_word == 1, "R8", int'(tune_word), 1);
    finish_run();
  end
endmodule